// File: doc/BRIEF.md
# Software Command Key Detector

This block sits beside an asynchronous-style memory port and watches the access cycles that the port completes. The chip-select, write-enable, busy level and 13-bit address are first brought into the local clock domain through a short synchronizer chain. A completed access is one full select cycle. The block then classifies each completed access as either a read or a write.

A strict six-step key made of read addresses arms one of two commands. The first five reads must hit a fixed list of addresses in a fixed order. The sixth read chooses the command: one address requests a non-volatile save and another requests a non-volatile restore. Any other access breaks the key. Once a command has been issued, the block ignores the port until the engine that performs the operation has raised its busy level and then dropped it again. The block does not move any data itself. It only emits one-clock request pulses and shows how far the key has progressed.

Top module: `keyseq_detector`

## Requirements
- R1: A completed select cycle counts when the synchronized chip-select deasserts (goes high). A read of the next expected key address moves `seq_pos` up by one. The key order is 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, and `seq_pos` runs from 0 to 5.
- R2: When `seq_pos` is 5, a read of 0x0F0F produces exactly one `store_req` pulse.
- R3: When `seq_pos` is 5, a read of 0x0F0E produces exactly one `recall_req` pulse.
- R4: A read of any other address breaks the key. `seq_pos` returns to 0 and no command is issued. The exception is a breaking read of 0x0000, which leaves `seq_pos` at 1.
- R5: A select cycle counts as a write if `wr_n` is sampled low at any point while select is low. A write returns `seq_pos` to 0 and issues no command, even when its address would have matched the key.
- R6: `store_req` and `recall_req` are never high together, and each one stays high for exactly one clock.
- R7: After a command, `seq_pos` reads 6 and every access is ignored. This lockout lasts until `busy` has been seen high and then low again, after which `seq_pos` returns to 0.
- R8: Outside the lockout, while `busy` is high, `seq_pos` is held at 0 and completed cycles are ignored.
- R9: During and after reset, `seq_pos` is 0 and both request pulses are low.
- R10: The address of a cycle is captured when the synchronized select falls. Changing `addr` later in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip-select strobe of the watched port, active low |
| wr_n | input | 1 | Write-enable level of the watched port, active low |
| busy | input | 1 | High while a save or restore operation is running |
| addr | input | 13 | Address of the watched port |
| store_req | output | 1 | One-clock save command pulse |
| recall_req | output | 1 | One-clock restore command pulse |
| seq_pos | output | 3 | Key steps matched (0 to 5), or 6 during lockout |

## Verification
The assertions check the following on every cycle:
- the two pulses never overlap, and neither lasts longer than one clock;
- each pulse can be traced back to a completed read of the matching final address at step 5;
- a matched read moves the step up by exactly one;
- a write clears the key;
- busy outside the lockout clears the key;
- no command appears while the block is locked.

Some behaviours are only shown by the bench's scenarios:
- the restart at step 1 after a breaking read of 0x0000;
- address capture at the falling edge of select;
- the full busy-high-then-low release of the lockout;
- whole keys completed back to back.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

  localparam int ADDR_W  = 13;
  localparam int POS_W   = 3;
  localparam int KEY_LEN = 5;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [POS_W-1:0]  pos_t;

  localparam addr_t CMD_SAVE = 13'h0F0F;
  localparam addr_t CMD_LOAD = 13'h0F0E;
  localparam pos_t  POS_LAST = pos_t'(KEY_LEN);
  localparam pos_t  POS_LOCK = pos_t'(KEY_LEN + 1);

  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_ARM   = 2'd1,
    ST_RUN   = 2'd2
  } mode_t;

  // Expected address for a given number of steps already matched.
  function automatic addr_t key_step(input pos_t idx);
    case (idx)
      3'd0:    key_step = 13'h0000;
      3'd1:    key_step = 13'h1555;
      3'd2:    key_step = 13'h0AAA;
      3'd3:    key_step = 13'h1FFF;
      default: key_step = 13'h10F0;
    endcase
  endfunction

  // Position after a read that breaks the key.
  function automatic pos_t restart_pos(input addr_t a);
    restart_pos = (a == key_step(3'd0)) ? 3'd1 : 3'd0;
  endfunction

endpackage

// File: rtl/ks_sync.sv
module ks_sync #(
  parameter int           W       = 16,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ks_cycle_class.sv
module ks_cycle_class
  import keyseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_sel_n,
  input  logic  s_wr_n,
  input  addr_t s_addr,
  output logic  cyc_done,
  output logic  cyc_write,
  output addr_t cyc_addr
);
  logic  prev_sel_n;
  logic  sel_fall;
  logic  wr_seen;
  addr_t addr_q;

  assign sel_fall = prev_sel_n & ~s_sel_n;
  assign cyc_done = ~prev_sel_n & s_sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_n <= 1'b1;
      wr_seen    <= 1'b0;
      addr_q     <= '0;
    end else begin
      prev_sel_n <= s_sel_n;
      if (sel_fall) begin
        addr_q  <= s_addr;
        wr_seen <= ~s_wr_n;
      end else if (!s_sel_n) begin
        wr_seen <= wr_seen | ~s_wr_n;
      end
    end
  end

  assign cyc_write = wr_seen;
  assign cyc_addr  = addr_q;

  // R1: a select cycle completes at most once per deassertion
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);
endmodule

// File: rtl/ks_key_match.sv
module ks_key_match
  import keyseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cyc_done,
  input  logic  cyc_write,
  input  addr_t cyc_addr,
  input  logic  s_busy,
  output logic  store_req,
  output logic  recall_req,
  output pos_t  seq_pos
);
  mode_t mode, mode_n;
  pos_t  pos, pos_n;
  logic  st_n, rc_n;

  // Named events for the assertions.
  logic ev_read, ev_write, live, key_hit, at_final;
  assign live     = (mode == ST_TRACK) && !s_busy;
  assign ev_read  = cyc_done && !cyc_write;
  assign ev_write = cyc_done && cyc_write;
  assign at_final = (pos == POS_LAST);
  assign key_hit  = !at_final && (cyc_addr == key_step(pos));

  always_comb begin
    mode_n = mode;
    pos_n  = pos;
    st_n   = 1'b0;
    rc_n   = 1'b0;
    case (mode)
      ST_TRACK: begin
        if (s_busy || ev_write) begin
          pos_n = '0;
        end else if (ev_read) begin
          if (at_final) begin
            if (cyc_addr == CMD_SAVE) begin
              st_n = 1'b1; mode_n = ST_ARM; pos_n = POS_LOCK;
            end else if (cyc_addr == CMD_LOAD) begin
              rc_n = 1'b1; mode_n = ST_ARM; pos_n = POS_LOCK;
            end else begin
              pos_n = restart_pos(cyc_addr);
            end
          end else if (key_hit) begin
            pos_n = pos + 3'd1;
          end else begin
            pos_n = restart_pos(cyc_addr);
          end
        end
      end
      ST_ARM: if (s_busy) mode_n = ST_RUN;
      ST_RUN: if (!s_busy) begin
        mode_n = ST_TRACK;
        pos_n  = '0;
      end
      default: begin
        mode_n = ST_TRACK;
        pos_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= ST_TRACK;
      pos        <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      mode       <= mode_n;
      pos        <= pos_n;
      store_req  <= st_n;
      recall_req <= rc_n;
    end
  end

  assign seq_pos = pos;

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  p_store_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  p_recall_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
  p_store_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(ev_read && live && at_final && cyc_addr == CMD_SAVE));
  p_recall_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> $past(ev_read && live && at_final && cyc_addr == CMD_LOAD));
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_read && live && key_hit) |=> seq_pos == $past(pos) + 3'd1);
  p_write_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_write && live) |=> (seq_pos == 3'd0 && !store_req && !recall_req));
  p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_TRACK && s_busy) |=> (seq_pos == 3'd0 && !store_req && !recall_req));
  p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != ST_TRACK) |=> (!store_req && !recall_req));
  p_lock_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != ST_TRACK) |-> seq_pos == POS_LOCK);
endmodule

// File: rtl/keyseq_detector.sv
module keyseq_detector
  import keyseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        wr_n,
  input  logic        busy,
  input  logic [12:0] addr,
  output logic        store_req,
  output logic        recall_req,
  output logic [2:0]  seq_pos
);
  localparam int SW = ADDR_W + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, {ADDR_W{1'b0}}};

  logic [SW-1:0] raw_bus, smp_bus;
  logic  s_busy, s_wr_n, s_sel_n;
  addr_t s_addr;
  logic  cyc_done, cyc_write;
  addr_t cyc_addr;

  assign raw_bus = {busy, wr_n, sel_n, addr};

  ks_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(smp_bus)
  );

  assign {s_busy, s_wr_n, s_sel_n, s_addr} = smp_bus;

  ks_cycle_class u_class (
    .clk(clk), .rst_n(rst_n),
    .s_sel_n(s_sel_n), .s_wr_n(s_wr_n), .s_addr(s_addr),
    .cyc_done(cyc_done), .cyc_write(cyc_write), .cyc_addr(cyc_addr)
  );

  ks_key_match u_match (
    .clk(clk), .rst_n(rst_n),
    .cyc_done(cyc_done), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .s_busy(s_busy),
    .store_req(store_req), .recall_req(recall_req), .seq_pos(seq_pos)
  );

  // R9: outputs idle right after reset
  p_reset_idle_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> (seq_pos == 3'd0 && !store_req && !recall_req));
endmodule

// File: tb/tb_keyseq_detector.sv
`timescale 1ns/1ps
module tb_keyseq_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        busy = 1'b0;
  logic [12:0] addr = '0;
  logic        store_req, recall_req;
  logic [2:0]  seq_pos;

  int checks = 0;
  int errors = 0;
  int st_cnt = 0, rc_cnt = 0, both_cnt = 0, wide_cnt = 0;
  int exp_st = 0, exp_rc = 0;
  logic st_prev = 1'b0, rc_prev = 1'b0;

  always #2 clk = ~clk;

  keyseq_detector dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .busy(busy),
    .addr(addr), .store_req(store_req), .recall_req(recall_req), .seq_pos(seq_pos)
  );

  always @(posedge clk) begin
    if (store_req) st_cnt++;
    if (recall_req) rc_cnt++;
    if (store_req && recall_req) both_cnt++;
    if ((store_req && st_prev) || (recall_req && rc_prev)) wide_cnt++;
    st_prev = store_req;
    rc_prev = recall_req;
  end

  // {addr, write, release, pos[2:0], store, recall}
  localparam int NV = 31;
  localparam logic [19:0] VEC [NV] = '{
    {13'h0000, 7'b0_0_001_0_0}, {13'h1555, 7'b0_0_010_0_0},
    {13'h0AAA, 7'b0_0_011_0_0}, {13'h1FFF, 7'b0_0_100_0_0},
    {13'h10F0, 7'b0_0_101_0_0}, {13'h0F0F, 7'b0_1_110_1_0},
    {13'h0000, 7'b0_0_001_0_0}, {13'h1555, 7'b0_0_010_0_0},
    {13'h0AAA, 7'b0_0_011_0_0}, {13'h1FFF, 7'b0_0_100_0_0},
    {13'h10F0, 7'b0_0_101_0_0}, {13'h0F0E, 7'b0_1_110_0_1},
    {13'h0000, 7'b0_0_001_0_0}, {13'h1555, 7'b0_0_010_0_0},
    {13'h1234, 7'b0_0_000_0_0}, {13'h0000, 7'b0_0_001_0_0},
    {13'h1555, 7'b0_0_010_0_0}, {13'h0000, 7'b0_0_001_0_0},
    {13'h1555, 7'b0_0_010_0_0}, {13'h0AAA, 7'b0_0_011_0_0},
    {13'h1FFF, 7'b0_0_100_0_0}, {13'h10F0, 7'b0_0_101_0_0},
    {13'h0F0D, 7'b0_0_000_0_0}, {13'h0000, 7'b0_0_001_0_0},
    {13'h1555, 7'b1_0_000_0_0}, {13'h0000, 7'b0_0_001_0_0},
    {13'h1555, 7'b0_0_010_0_0}, {13'h0AAA, 7'b0_0_011_0_0},
    {13'h1FFF, 7'b0_0_100_0_0}, {13'h10F0, 7'b0_0_101_0_0},
    {13'h0F0F, 7'b1_0_000_0_0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic [12:0] a, input logic wr);
    @(negedge clk);
    addr = a; wr_n = ~wr; sel_n = 1'b0;
    wait_n(4);
    sel_n = 1'b1; wr_n = 1'b1;
    wait_n(6);
  endtask

  task automatic release_busy();
    busy = 1'b1; wait_n(6);
    busy = 1'b0; wait_n(6);
  endtask

  task automatic check_counts(input string tag);
    check({tag, " store count"}, st_cnt, exp_st);
    check({tag, " recall count"}, rc_cnt, exp_rc);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(4);
    check("R9 reset seq_pos", int'(seq_pos), 0);
    check("R9 reset store_req", int'(store_req), 0);
    check("R9 reset recall_req", int'(recall_req), 0);
    rst_n = 1'b1;
    wait_n(3);
    check("R9 after reset seq_pos", int'(seq_pos), 0);

    // Vector table: R1 R2 R3 R4 R5 and R7 release
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][19:7], VEC[i][6]);
      exp_st += int'(VEC[i][1]);
      exp_rc += int'(VEC[i][0]);
      check($sformatf("R1/R4/R5 vec %0d seq_pos", i), int'(seq_pos), int'(VEC[i][4:2]));
      check_counts($sformatf("R2/R3 vec %0d", i));
      if (VEC[i][5]) begin
        release_busy();
        check($sformatf("R7 vec %0d released seq_pos", i), int'(seq_pos), 0);
      end
    end

    // R7: lockout ignores accesses until busy high then low
    access(13'h0000, 1'b0); access(13'h1555, 1'b0); access(13'h0AAA, 1'b0);
    access(13'h1FFF, 1'b0); access(13'h10F0, 1'b0); access(13'h0F0F, 1'b0);
    exp_st++;
    check("R7 locked seq_pos", int'(seq_pos), 6);
    access(13'h0000, 1'b0);
    check("R7 access ignored seq_pos", int'(seq_pos), 6);
    access(13'h0F0E, 1'b0);
    check_counts("R7 no command during lock");
    busy = 1'b1; wait_n(6);
    access(13'h0000, 1'b0);
    check("R7 busy high still locked", int'(seq_pos), 6);
    busy = 1'b0; wait_n(6);
    check("R7 release seq_pos", int'(seq_pos), 0);

    // R8: busy outside lockout clears and blocks the key
    access(13'h0000, 1'b0); access(13'h1555, 1'b0);
    check("R8 pre busy seq_pos", int'(seq_pos), 2);
    busy = 1'b1; wait_n(6);
    check("R8 busy clears seq_pos", int'(seq_pos), 0);
    access(13'h0000, 1'b0);
    check("R8 access ignored under busy", int'(seq_pos), 0);
    busy = 1'b0; wait_n(6);
    check("R8 after busy seq_pos", int'(seq_pos), 0);

    // R10: address captured at select fall
    @(negedge clk);
    addr = 13'h0000; sel_n = 1'b0;
    wait_n(4);
    addr = 13'h1555;
    wait_n(4);
    sel_n = 1'b1;
    wait_n(6);
    check("R10 late address change ignored", int'(seq_pos), 1);
    access(13'h1555, 1'b0);
    check("R10 key continues", int'(seq_pos), 2);

    // R9: reset mid-key
    access(13'h0AAA, 1'b0);
    check("R9 mid-key seq_pos", int'(seq_pos), 3);
    rst_n = 1'b0; wait_n(2);
    check("R9 reset mid-key seq_pos", int'(seq_pos), 0);
    rst_n = 1'b1; wait_n(3);
    access(13'h1FFF, 1'b0);
    check("R9 key forgotten after reset", int'(seq_pos), 0);

    // R6: exclusivity and single-cycle pulses seen over the whole run
    check_counts("R6 final");
    check("R6 overlapping pulses", both_cnt, 0);
    check("R6 pulses wider than one clock", wide_cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule